// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the entry step of exception handling for a simple 32-bit in-order core. Each cycle it looks at four possible causes: a user break (before or after the instruction executes), a privileged instruction found in a delay slot while the core runs in user mode, a misaligned data access, and a rising edge on the non-maskable interrupt pin. It picks exactly one cause by fixed priority. On the following clock edge it presents a complete entry record: the PC to save, the SR to save, the event code and which event register it belongs to, the new SR, and the handler address.

Each cause has its own event code and its own rule for which PC is saved. The core supplies the PC of the current instruction, the PC of the instruction after it, and the PC of the delayed branch that owns the current slot. The non-maskable interrupt ignores the interrupt-level field of SR. It is blocked while SR's block bit is set, unless the core raises the block-override input. An edge that arrives while the interrupt is blocked is latched as pending and is taken later.

Top module: `exc_entry_seq`

## Requirements
- R1: When a cause is accepted, `exc_take` is high for the cycle after the clock edge that sampled the request. In that same cycle `exc_ssr` equals the SR sampled at that edge, and `exc_sr` equals that SR with bits 30 (mode), 29 (bank) and 28 (block) set to 1. All outputs are updated on that single edge.
- R2: If `priv_op` and `in_slot` are both high while SR bit 30 is 0, the block enters with code 0x1A0 and `exc_is_int`=0, saves `br_pc`, and branches to `vbr`+0x100. With SR bit 30 at 1, or with `in_slot` low, no entry occurs.
- R3: `brk_req` causes entry with code 0x1E0 and target `vbr`+0x100. When `brk_post`=1 the saved PC is `next_pc`; when `brk_post`=0 it is `cur_pc`.
- R4: `mem_req` with `mem_size` 2'b01 (word) and address low bits 01 or 11, or with `mem_size` 2'b10 (longword) and any nonzero low bits, causes entry with code 0x5C0. The saved PC is `cur_pc` and the target is `vbr`+0x100. Any other combination, including size 2'b00 (byte), causes no entry.
- R5: A 0-to-1 transition of `nmi_pin` causes entry with code 0x1C0 and `exc_is_int`=1, saves `next_pc`, and branches to `vbr`+0x600. A pin that stays high causes only one entry.
- R6: While SR bit 28 is 1 and `nmi_blmsk` is 0, the interrupt is not taken. The edge stays pending and is taken at the first edge where SR bit 28 is 0 or `nmi_blmsk` is 1.
- R7: While SR bit 28 is 1 and `nmi_blmsk` is 1, the interrupt is accepted. It is accepted whatever the value of SR bits 7:4.
- R8: When several causes are present at the same edge, the order is break, then delay-slot privilege, then misaligned access, then interrupt, and only the winner is entered. An interrupt that loses stays pending.
- R9: After reset `exc_take` is 0, all record outputs are 0, and no interrupt is pending.
- R10: While `exc_take` is 0, the record outputs keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | 32 | PC of the instruction now executing |
| next_pc | input | 32 | PC of the following instruction |
| br_pc | input | 32 | PC of the delayed branch owning the current slot |
| in_slot | input | 1 | Current instruction sits in a delay slot |
| priv_op | input | 1 | Current instruction is privileged |
| brk_req | input | 1 | User break condition hit |
| brk_post | input | 1 | Break is post-execution (1) or pre-execution (0) |
| mem_req | input | 1 | Data access in progress |
| mem_size | input | 2 | Access size: 00 byte, 01 word, 10 longword |
| mem_addr_lo | input | 2 | Low two bits of the data address |
| nmi_pin | input | 1 | Non-maskable interrupt pin |
| nmi_blmsk | input | 1 | Allow the interrupt while the block bit is set |
| sr_in | input | 32 | Current status register |
| vbr | input | 32 | Vector base |
| exc_take | output | 1 | One-cycle entry pulse |
| exc_spc | output | 32 | PC to save |
| exc_ssr | output | 32 | SR to save |
| exc_code | output | 12 | Event code |
| exc_is_int | output | 1 | Code targets the interrupt event registers (1) or the exception event register (0) |
| exc_sr | output | 32 | New SR |
| exc_tgt | output | 32 | Handler address |

## Verification
Several synchronous causes can occur together with an interrupt edge at the same clock edge. The vector table drives break, privilege, misaligned-access and pin edges together in the same cycle and checks that only the top-ranked code, saved PC and target appear. A directed test raises the pin together with a misaligned access. It checks that the access is entered first and that the interrupt entry follows at the next edge, with no second pin edge.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int XLEN     = 32,
  parameter int CODE_W   = 12,
  parameter int MD_BIT   = 30,
  parameter int RB_BIT   = 29,
  parameter int BL_BIT   = 28,
  parameter logic [CODE_W-1:0] CODE_PRIV = 12'h1A0,
  parameter logic [CODE_W-1:0] CODE_BRK  = 12'h1E0,
  parameter logic [CODE_W-1:0] CODE_ADR  = 12'h5C0,
  parameter logic [CODE_W-1:0] CODE_NMI  = 12'h1C0,
  parameter logic [XLEN-1:0]   OFF_GEN   = 32'h100,
  parameter logic [XLEN-1:0]   OFF_NMI   = 32'h600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   next_pc,
  input  logic [XLEN-1:0]   br_pc,
  input  logic              in_slot,
  input  logic              priv_op,
  input  logic              brk_req,
  input  logic              brk_post,
  input  logic              mem_req,
  input  logic [1:0]        mem_size,
  input  logic [1:0]        mem_addr_lo,
  input  logic              nmi_pin,
  input  logic              nmi_blmsk,
  input  logic [XLEN-1:0]   sr_in,
  input  logic [XLEN-1:0]   vbr,
  output logic              exc_take,
  output logic [XLEN-1:0]   exc_spc,
  output logic [XLEN-1:0]   exc_ssr,
  output logic [CODE_W-1:0] exc_code,
  output logic              exc_is_int,
  output logic [XLEN-1:0]   exc_sr,
  output logic [XLEN-1:0]   exc_tgt
);

  localparam logic [XLEN-1:0] ENTRY_SET =
    (XLEN'(1) << MD_BIT) | (XLEN'(1) << RB_BIT) | (XLEN'(1) << BL_BIT);

  logic nmi_pin_q, nmi_pend;
  logic user_mode, blocked;
  logic word_bad, long_bad;
  logic c_brk, c_priv, c_adr, nmi_avail, c_nmi;
  logic take_d, int_d;
  logic [CODE_W-1:0] code_d;
  logic [XLEN-1:0]   spc_d, off_d;

  assign user_mode = ~sr_in[MD_BIT];
  assign blocked   = sr_in[BL_BIT] & ~nmi_blmsk;

  assign word_bad = (mem_size == 2'b01) & mem_addr_lo[0];
  assign long_bad = (mem_size == 2'b10) & (|mem_addr_lo);

  assign c_brk     = brk_req;
  assign c_priv    = priv_op & in_slot & user_mode;
  assign c_adr     = mem_req & (word_bad | long_bad);
  assign nmi_avail = nmi_pend | (nmi_pin & ~nmi_pin_q);
  assign c_nmi     = nmi_avail & ~blocked;

  always_comb begin
    take_d = 1'b1;
    int_d  = 1'b0;
    off_d  = OFF_GEN;
    code_d = '0;
    spc_d  = cur_pc;
    if (c_brk) begin
      code_d = CODE_BRK;
      spc_d  = brk_post ? next_pc : cur_pc;
    end else if (c_priv) begin
      code_d = CODE_PRIV;
      spc_d  = br_pc;
    end else if (c_adr) begin
      code_d = CODE_ADR;
    end else if (c_nmi) begin
      code_d = CODE_NMI;
      spc_d  = next_pc;
      int_d  = 1'b1;
      off_d  = OFF_NMI;
    end else begin
      take_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_pin_q  <= 1'b0;
      nmi_pend   <= 1'b0;
      exc_take   <= 1'b0;
      exc_spc    <= '0;
      exc_ssr    <= '0;
      exc_code   <= '0;
      exc_is_int <= 1'b0;
      exc_sr     <= '0;
      exc_tgt    <= '0;
    end else begin
      nmi_pin_q <= nmi_pin;
      nmi_pend  <= nmi_avail & ~(take_d & int_d);
      exc_take  <= take_d;
      if (take_d) begin
        exc_spc    <= spc_d;
        exc_ssr    <= sr_in;
        exc_code   <= code_d;
        exc_is_int <= int_d;
        exc_sr     <= sr_in | ENTRY_SET;
        exc_tgt    <= vbr + off_d;
      end
    end
  end

  AST_SR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |-> ((exc_sr & ENTRY_SET) == ENTRY_SET)); // R1
  AST_SSR_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |-> (exc_ssr == $past(sr_in))); // R1
  AST_USER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_op && in_slot && !user_mode && !brk_req && !mem_req && !nmi_avail) |=> !exc_take); // R2
  AST_NMI_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && exc_is_int) |-> (exc_tgt == $past(vbr) + OFF_NMI && exc_code == CODE_NMI)); // R5
  AST_NMI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_in[BL_BIT] && !nmi_blmsk) |=> !(exc_take && exc_is_int)); // R6
  AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_avail && !(exc_take && exc_is_int) && (brk_req || blocked)) |=> nmi_pend); // R8
  AST_BRK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> (exc_take && exc_code == CODE_BRK)); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_take |-> ($stable(exc_spc) && $stable(exc_code) && $stable(exc_tgt))); // R10

endmodule

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cur_pc, next_pc, br_pc, sr_in, vbr;
  logic        in_slot, priv_op, brk_req, brk_post, mem_req, nmi_pin, nmi_blmsk;
  logic [1:0]  mem_size, mem_addr_lo;
  logic        exc_take, exc_is_int;
  logic [31:0] exc_spc, exc_ssr, exc_sr, exc_tgt;
  logic [11:0] exc_code;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  exc_entry_seq u_exc_entry_seq (.*);

  localparam logic [31:0] PC_CUR = 32'h1000_0010, PC_NXT = 32'h1000_0014,
                          PC_BR  = 32'h1000_000C, VBASE  = 32'h8000_0000;
  localparam logic [31:0] ENT = 32'h7000_0000;

  // brk post priv slot mem size alo nmi md bl blmsk | take code sel(0cur 1next 2br) int
  localparam int NV = 18;
  localparam logic [28:0] TBL [0:NV-1] = '{
    {1'b0,1'b0,1'b1,1'b1,1'b0,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0, 1'b1,12'h1A0,2'd2,1'b0},
    {1'b0,1'b0,1'b1,1'b1,1'b0,2'b00,2'b00,1'b0,1'b1,1'b0,1'b0, 1'b0,12'h000,2'd0,1'b0},
    {1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0, 1'b0,12'h000,2'd0,1'b0},
    {1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0, 1'b1,12'h1E0,2'd0,1'b0},
    {1'b1,1'b1,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0, 1'b1,12'h1E0,2'd1,1'b0},
    {1'b0,1'b0,1'b0,1'b0,1'b1,2'b01,2'b01,1'b0,1'b0,1'b0,1'b0, 1'b1,12'h5C0,2'd0,1'b0},
    {1'b0,1'b0,1'b0,1'b0,1'b1,2'b01,2'b10,1'b0,1'b0,1'b0,1'b0, 1'b0,12'h000,2'd0,1'b0},
    {1'b0,1'b0,1'b0,1'b0,1'b1,2'b01,2'b11,1'b0,1'b1,1'b0,1'b0, 1'b1,12'h5C0,2'd0,1'b0},
    {1'b0,1'b0,1'b0,1'b0,1'b1,2'b10,2'b10,1'b0,1'b0,1'b0,1'b0, 1'b1,12'h5C0,2'd0,1'b0},
    {1'b0,1'b0,1'b0,1'b0,1'b1,2'b10,2'b00,1'b0,1'b0,1'b0,1'b0, 1'b0,12'h000,2'd0,1'b0},
    {1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b11,1'b0,1'b0,1'b0,1'b0, 1'b0,12'h000,2'd0,1'b0},
    {1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b1,1'b0,1'b0,1'b0, 1'b1,12'h1C0,2'd1,1'b1},
    {1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b1,1'b1,1'b1,1'b1, 1'b1,12'h1C0,2'd1,1'b1},
    {1'b1,1'b0,1'b1,1'b1,1'b0,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0, 1'b1,12'h1E0,2'd0,1'b0},
    {1'b0,1'b0,1'b1,1'b1,1'b1,2'b10,2'b01,1'b0,1'b0,1'b0,1'b0, 1'b1,12'h1A0,2'd2,1'b0},
    {1'b0,1'b0,1'b0,1'b0,1'b1,2'b01,2'b01,1'b1,1'b0,1'b0,1'b0, 1'b1,12'h5C0,2'd0,1'b0},
    {1'b1,1'b1,1'b1,1'b1,1'b1,2'b10,2'b11,1'b1,1'b0,1'b0,1'b0, 1'b1,12'h1E0,2'd1,1'b0},
    {1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,1'b1,1'b1,1'b0, 1'b1,12'h1E0,2'd0,1'b0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    brk_req = 0; brk_post = 0; priv_op = 0; in_slot = 0; mem_req = 0;
    mem_size = 2'b00; mem_addr_lo = 2'b00; nmi_blmsk = 0; sr_in = 32'h0000_00F0;
  endtask

  task automatic check_entry(input string req, input logic [11:0] code,
                             input logic [31:0] spc, input bit isint, input logic [31:0] sr);
    chk(exc_take === 1'b1, req, "take", {31'b0, exc_take}, 32'd1);
    chk(exc_code === code, req, "code", {20'b0, exc_code}, {20'b0, code});
    chk(exc_spc === spc, req, "spc", exc_spc, spc);
    chk(exc_is_int === isint, req, "is_int", {31'b0, exc_is_int}, {31'b0, isint});
    chk(exc_ssr === sr, "R1", "ssr", exc_ssr, sr);
    chk(exc_sr === (sr | ENT), "R1", "new sr", exc_sr, sr | ENT);
    chk(exc_tgt === VBASE + (isint ? 32'h600 : 32'h100), req, "target",
        exc_tgt, VBASE + (isint ? 32'h600 : 32'h100));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    cur_pc = PC_CUR; next_pc = PC_NXT; br_pc = PC_BR; vbr = VBASE;
    nmi_pin = 0; idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(exc_take === 1'b0, "R9", "take", {31'b0, exc_take}, 0);
    chk(exc_spc === 0 && exc_ssr === 0 && exc_sr === 0 && exc_tgt === 0 && exc_code === 0,
        "R9", "record", exc_spc | exc_tgt, 0);
    rst_n = 1;
    @(negedge clk);
    chk(exc_take === 1'b0, "R9", "no pending after reset", {31'b0, exc_take}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      logic [31:0] sr, spc;
      string req;
      int ncause;
      v = TBL[i];
      sr = 32'h0000_00F0 | ({31'b0, v[18]} << 30) | ({31'b0, v[17]} << 28);
      ncause = int'(v[28]) + int'(v[26]) + int'(v[24]) + int'(v[19]);
      if (ncause > 1) req = "R8";
      else if (v[19] && v[17]) req = "R7";
      else if (v[28]) req = "R3";
      else if (v[26]) req = "R2";
      else if (v[24]) req = "R4";
      else req = "R5";
      spc = (v[2:1] == 2'd0) ? PC_CUR : (v[2:1] == 2'd1) ? PC_NXT : PC_BR;
      brk_req = v[28]; brk_post = v[27]; priv_op = v[26]; in_slot = v[25];
      mem_req = v[24]; mem_size = v[23:22]; mem_addr_lo = v[21:20];
      nmi_pin = v[19]; sr_in = sr; nmi_blmsk = v[16];
      @(negedge clk);
      if (v[15]) check_entry(req, v[14:3], spc, v[0], sr);
      else chk(exc_take === 1'b0, req, "no entry", {31'b0, exc_take}, 0);
      idle();
      @(negedge clk);
      nmi_pin = 0;
      @(negedge clk);
    end

    // R10: outputs hold with no entry
    idle();
    brk_req = 1; brk_post = 1;
    @(negedge clk);
    idle();
    @(negedge clk);
    chk(exc_take === 1'b0, "R10", "take idle", {31'b0, exc_take}, 0);
    chk(exc_spc === PC_NXT && exc_code === 12'h1E0, "R10", "held spc", exc_spc, PC_NXT);

    // R6: held while blocked, taken once block clears
    idle();
    sr_in = 32'h1000_00F0;
    nmi_pin = 1;
    repeat (3) begin
      @(negedge clk);
      chk(exc_take === 1'b0, "R6", "held off", {31'b0, exc_take}, 0);
    end
    nmi_pin = 0;
    @(negedge clk);
    chk(exc_take === 1'b0, "R6", "still held", {31'b0, exc_take}, 0);
    sr_in = 32'h0000_00F0;
    @(negedge clk);
    check_entry("R6", 12'h1C0, PC_NXT, 1'b1, 32'h0000_00F0);
    @(negedge clk);
    chk(exc_take === 1'b0, "R6", "single entry", {31'b0, exc_take}, 0);

    // R6: pending, then override bit raised
    sr_in = 32'h1000_0000;
    nmi_pin = 1;
    @(negedge clk);
    chk(exc_take === 1'b0, "R6", "held off", {31'b0, exc_take}, 0);
    nmi_blmsk = 1;
    @(negedge clk);
    check_entry("R6", 12'h1C0, PC_NXT, 1'b1, 32'h1000_0000);

    // R5: level held high gives no retrigger
    idle();
    repeat (3) begin
      @(negedge clk);
      chk(exc_take === 1'b0, "R5", "no retrigger", {31'b0, exc_take}, 0);
    end
    nmi_pin = 0;
    @(negedge clk);

    // R8: losing interrupt stays pending and follows
    mem_req = 1; mem_size = 2'b10; mem_addr_lo = 2'b10; nmi_pin = 1;
    @(negedge clk);
    check_entry("R8", 12'h5C0, PC_CUR, 1'b0, 32'h0000_00F0);
    idle();
    @(negedge clk);
    check_entry("R8", 12'h1C0, PC_NXT, 1'b1, 32'h0000_00F0);
    @(negedge clk);
    chk(exc_take === 1'b0, "R8", "only one interrupt entry", {31'b0, exc_take}, 0);
    nmi_pin = 0;
    @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule